// File: doc/BRIEF.md
# Two-Wire Bus Slave Byte Engine

This block is the slave end of a two-wire serial bus, running entirely on a fast system clock. The clock and data lines are treated as ordinary inputs. They are synchronised, and their edges are found by comparing each sample with the one before it. From those edges the block recognises the bus conditions that open and close a transfer. It assembles incoming bits into bytes and answers each accepted byte with an acknowledge. On reads it serialises the bytes supplied by its client.

The client side is byte-level and is meant for a small memory controller:
- a strobe with the received byte;
- a request for the next byte to send;
- single-cycle event pulses for START and STOP;
- a busy input.

While busy is high, the engine answers no byte. To the bus master the device then looks absent until the internal write finishes. The data line is open-drain: the block only ever pulls it low, through an output enable.

Top module: `twi_slave_core`

## Requirements
- R1: After reset, `sda_oe_o`, `rx_valid_o`, `tx_req_o`, `start_o` and `stop_o` are all 0.
- R2: Each START (SDA falls while SCL is high), including a repeated START, gives one single-cycle `start_o` pulse. Each STOP (SDA rises while SCL is high) gives one single-cycle `stop_o` pulse and returns the engine to idle.
- R3: The first byte after a START is received MSB first. Bits 7..1 are a 7-bit address and bit 0 is the direction (1 = read, 0 = write). When the address equals `DEV_ADDR` and `busy_i` is low, the slave holds SDA low through the ninth clock.
- R4: On an address mismatch the slave does not acknowledge. Until the next START it ignores all traffic: it drives no bit and gives no `rx_valid_o`.
- R5: In a write transfer, every data byte is received MSB first. Each one is presented on `rx_byte_o` with a single-cycle `rx_valid_o` pulse and is acknowledged.
- R6: If `busy_i` is high when a received byte (address or data) completes, that byte gets no acknowledge and no strobe. The engine then ignores the bus until the next START.
- R7: In a read transfer, `tx_req_o` pulses once during the ninth clock before each byte is sent. `tx_byte_i` is sampled at the following SCL falling edge and shifted out MSB first.
- R8: After a sent byte, a master acknowledge (SDA low on the ninth clock) leads to the next byte. A not-acknowledge makes the slave release SDA and drive nothing more until the next START.
- R9: `sda_oe_o` changes only while SCL is low, and never within two system clocks of an SCL falling edge at the pin.
- R10: A START in the middle of a byte discards the partial byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_i | input | 1 | Internal programming in progress, suppresses acknowledges |
| start_o | output | 1 | One-cycle pulse on START |
| stop_o | output | 1 | One-cycle pulse on STOP |
| rx_byte_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| tx_req_o | output | 1 | One-cycle request for the next byte to send |
| tx_byte_i | input | 8 | Byte to send, sampled at the next SCL fall after the request |

## Verification
Most faults in the engine show up directly on the bus. A wrong state or bit count makes the acknowledge appear on the wrong clock, or not at all, and the master model sees this within the same byte. A misaligned shift register produces received or sent bytes that differ from the bench's independent record, and the error is caught at the end of that byte. A broken launch delay is caught on the very next SCL falling edge, because the bench watches every change of the output enable against the pin-level SCL.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [W-1:0]             prev_q;

  // idle bus is high: reset to ones so no false edge leaves reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
      prev_q <= '1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], line_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic scl_s_i,
  input  logic scl_q_i,
  input  logic sda_s_i,
  input  logic sda_q_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_high;

  assign scl_high   = scl_s_i & scl_q_i;
  assign scl_rise_o = scl_s_i & ~scl_q_i;
  assign scl_fall_o = ~scl_s_i & scl_q_i;
  assign start_o    = scl_high & sda_q_i & ~sda_s_i;
  assign stop_o     = scl_high & ~sda_q_i & sda_s_i;
endmodule

// File: rtl/twi_oe_launch.sv
module twi_oe_launch #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic want_i,
  output logic oe_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;

  // the new level is applied HOLD_CYC clocks after the SCL fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      oe_o  <= 1'b0;
    end else begin
      if (fall_i)             cnt_q <= CW'(HOLD_CYC);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1))    oe_o  <= want_i;
    end
  end
endmodule

// File: rtl/twi_slave_core.sv
module twi_slave_core
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2,
  parameter int         HOLD_CYC    = 4,
  parameter int         DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              busy_i,
  output logic              start_o,
  output logic              stop_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              tx_req_o,
  input  logic [DATA_W-1:0] tx_byte_i
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] LAST = BW'(DATA_W);

  logic scl_s, scl_q, sda_s, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  twi_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({scl_i, sda_i}),
    .sync_o ({scl_s, sda_s}),
    .prev_o ({scl_q, sda_q})
  );

  twi_cond_detect u_det (
    .scl_s_i    (scl_s),
    .scl_q_i    (scl_q),
    .sda_s_i    (sda_s),
    .sda_q_i    (sda_q),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  twi_state_e        state_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] rx_sh_q, tx_sh_q;
  logic              rw_q, mack_q;
  logic              oe_want;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
      tx_req_o   <= 1'b0;
    end else begin
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      rx_valid_o <= 1'b0;
      tx_req_o   <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
        stop_o  <= 1'b1;
      end else if (start_det) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        start_o <= 1'b1;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise && bit_q != LAST) begin
              rx_sh_q <= {rx_sh_q[DATA_W-2:0], sda_s};
              bit_q   <= bit_q + 1'b1;
            end
            if (scl_fall && bit_q == LAST) begin
              if (busy_i) begin
                state_q <= ST_IDLE;
              end else if (state_q == ST_ADDR) begin
                if (rx_sh_q[DATA_W-1:1] == DEV_ADDR) begin
                  rw_q    <= rx_sh_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                rx_byte_o  <= rx_sh_q;
                rx_valid_o <= 1'b1;
                state_q    <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_rise && rw_q) tx_req_o <= 1'b1;
            if (scl_fall) begin
              bit_q <= '0;
              if (rw_q) begin
                tx_sh_q <= tx_byte_i;
                state_q <= ST_RD;
              end else begin
                state_q <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              bit_q   <= '0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) bit_q <= bit_q + 1'b1;
            if (scl_fall) begin
              if (bit_q == LAST)    state_q <= ST_RD_ACK;
              else if (bit_q != '0) tx_sh_q <= tx_sh_q << 1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
              if (!sda_s) tx_req_o <= 1'b1;
            end
            if (scl_fall) begin
              bit_q <= '0;
              if (mack_q) begin
                tx_sh_q <= tx_byte_i;
                state_q <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ADDR_ACK, ST_WR_ACK: oe_want = 1'b1;
      ST_RD:                  oe_want = ~tx_sh_q[DATA_W-1];
      default:                oe_want = 1'b0;
    endcase
  end

  twi_oe_launch #(.HOLD_CYC(HOLD_CYC)) u_launch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (scl_fall),
    .want_i (oe_want),
    .oe_o   (sda_oe_o)
  );
endmodule

// File: rtl/twi_slave_core_chk.sv
module twi_slave_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_oe_o,
  input logic busy_i,
  input logic start_o,
  input logic stop_o,
  input logic rx_valid_o,
  input logic tx_req_o
);
  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r2_no_start_and_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  a_r5_rx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r6_no_strobe_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !$past(busy_i));
  a_r7_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);
  a_r9_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind twi_slave_core twi_slave_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .sda_oe_o   (sda_oe_o),
  .busy_i     (busy_i),
  .start_o    (start_o),
  .stop_o     (stop_o),
  .rx_valid_o (rx_valid_o),
  .tx_req_o   (tx_req_o)
);

// File: tb/sim_twi_slave_core.sv
module sim_twi_slave_core;
  localparam logic [6:0] ADDR = 7'h50;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, start_p, stop_p, rx_valid, tx_req;
  logic [7:0] rx_byte, tx_byte = 8'h00;
  wire sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  twi_slave_core #(.DEV_ADDR(ADDR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .busy_i(busy), .start_o(start_p), .stop_o(stop_p),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .tx_req_o(tx_req),
    .tx_byte_i(tx_byte)
  );

  int n_chk = 0, n_fail = 0;
  int rx_cnt = 0, req_cnt = 0, start_cnt = 0, stop_cnt = 0, hold_viol = 0;
  logic [7:0] rxlog [64];
  logic [7:0] txq [64];
  bit done = 0;

  always @(posedge clk) begin
    logic [7:0] v;
    if (rx_valid) begin rxlog[rx_cnt % 64] <= rx_byte; rx_cnt <= rx_cnt + 1; end
    if (start_p) start_cnt <= start_cnt + 1;
    if (stop_p) stop_cnt <= stop_cnt + 1;
    if (tx_req) begin
      v = 8'($urandom);
      tx_byte <= v;
      txq[req_cnt % 64] <= v;
      req_cnt <= req_cnt + 1;
    end
  end

  // R9 monitor at the pins
  logic scl_d = 1'b1, oe_d = 1'b0;
  int since_fall = 100;
  always @(posedge clk) begin
    if (rst_n && oe_d !== sda_oe && (scl || since_fall < 2)) hold_viol <= hold_viol + 1;
    since_fall <= (scl_d && !scl) ? 0 : since_fall + 1;
    scl_d <= scl;
    oe_d  <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin sda_m = 1'b1; w(H/2); scl = 1'b1; w(H/2); end
    sda_m = 1'b0; w(H/2); scl = 1'b0; w(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(H/2); scl = 1'b1; w(H/2); sda_m = 1'b1; w(H);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b; w(H/2); scl = 1'b1; w(H/2); seen = sda_bus; w(H/2); scl = 1'b0; w(H/2);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); b[i] = s; end
    bus_bit(!mack, s);
  endtask

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input bit rd);
    return {a, rd};
  endfunction

  initial begin
    w(200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b, exp_b;
    int base, k0, len;
    void'($urandom(32'h5eed));
    w(4);
    chk(sda_oe == 0 && rx_valid == 0 && tx_req == 0 && start_p == 0 && stop_p == 0,
        "R1 reset outputs", {sda_oe, rx_valid, tx_req, start_p, stop_p}, 0);
    rst_n = 1'b1;
    w(10);

    // R3 / R5 / R2 directed write
    k0 = start_cnt;
    bus_start();
    wr_byte(addr_byte(ADDR, 0), ack);
    chk(ack, "R3 address ack", ack, 1);
    for (int i = 0; i < 6; i++) begin
      b = (i == 0) ? 8'h80 : (i == 1) ? 8'h01 : 8'($urandom);
      wr_byte(b, ack);
      chk(ack, "R5 data ack", ack, 1);
      w(2);
      chk(rxlog[(rx_cnt - 1) % 64] == b, "R5 data byte", rxlog[(rx_cnt - 1) % 64], b);
    end
    base = stop_cnt;
    bus_stop();
    chk(start_cnt == k0 + 1, "R2 start pulses", start_cnt - k0, 1);
    chk(stop_cnt == base + 1, "R2 stop pulses", stop_cnt - base, 1);

    // R4 mismatch
    base = rx_cnt;
    bus_start();
    wr_byte(addr_byte(ADDR ^ 7'h01, 0), ack);
    chk(!ack, "R4 mismatch no ack", ack, 0);
    wr_byte(8'h00, ack);
    chk(!ack, "R4 ignored data no ack", ack, 0);
    chk(rx_cnt == base, "R4 no strobe", rx_cnt - base, 0);
    bus_stop();

    // R6 busy
    busy = 1'b1;
    bus_start();
    wr_byte(addr_byte(ADDR, 0), ack);
    chk(!ack, "R6 busy address no ack", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    wr_byte(addr_byte(ADDR, 0), ack);
    wr_byte(8'h3c, ack);
    chk(ack, "R6 idle data ack", ack, 1);
    base = rx_cnt;
    busy = 1'b1;
    wr_byte(8'hc3, ack);
    chk(!ack, "R6 busy data no ack", ack, 0);
    busy = 1'b0;
    wr_byte(8'h5a, ack);
    chk(!ack, "R6 ignored until start", ack, 0);
    chk(rx_cnt == base, "R6 no strobe", rx_cnt - base, 0);
    bus_stop();

    // R7 / R8 read
    base = req_cnt;
    bus_start();
    wr_byte(addr_byte(ADDR, 1), ack);
    chk(ack, "R3 read address ack", ack, 1);
    for (int i = 0; i < 5; i++) begin
      rd_byte(i != 4, b);
      exp_b = txq[(base + i) % 64];
      chk(b == exp_b, "R7 read byte", b, exp_b);
    end
    chk(req_cnt == base + 5, "R7 request count", req_cnt - base, 5);
    rd_byte(0, b);
    chk(b == 8'hff, "R8 released after nack", b, 8'hff);
    chk(req_cnt == base + 5, "R8 no request after nack", req_cnt - base, 5);
    bus_stop();

    // R10 repeated START mid byte
    k0 = start_cnt;
    base = rx_cnt;
    bus_start();
    wr_byte(addr_byte(ADDR, 0), ack);
    begin
      logic s;
      for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
    end
    bus_start();
    wr_byte(addr_byte(ADDR, 0), ack);
    chk(ack, "R10 address after restart", ack, 1);
    wr_byte(8'h96, ack);
    w(2);
    chk(rx_cnt == base + 1 && rxlog[base % 64] == 8'h96, "R10 byte after restart",
        rxlog[base % 64], 8'h96);
    chk(start_cnt == k0 + 2, "R2 repeated start pulse", start_cnt - k0, 2);
    bus_stop();

    // random mix
    for (int t = 0; t < 16; t++) begin
      len = 1 + ($urandom % 4);
      bus_start();
      if ($urandom % 2) begin
        wr_byte(addr_byte(ADDR, 0), ack);
        chk(ack, "R3 random address", ack, 1);
        for (int i = 0; i < len; i++) begin
          b = 8'($urandom);
          wr_byte(b, ack);
          w(2);
          chk(ack && rxlog[(rx_cnt - 1) % 64] == b, "R5 random write",
              rxlog[(rx_cnt - 1) % 64], b);
        end
      end else begin
        base = req_cnt;
        wr_byte(addr_byte(ADDR, 1), ack);
        chk(ack, "R3 random address", ack, 1);
        for (int i = 0; i < len; i++) begin
          rd_byte(i != len - 1, b);
          exp_b = txq[(base + i) % 64];
          chk(b == exp_b, "R7 random read", b, exp_b);
        end
      end
      bus_stop();
    end

    chk(hold_viol == 0, "R9 output launch timing", hold_viol, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule